// File: doc/BRIEF.md
# Dynamic Bus-Sizing Lane Steering Adapter

This block connects a 32-bit processor bus to a memory system in which 32-bit, 16-bit and 8-bit devices coexist. For each bus cycle it checks the word address against two configurable regions, one for 16-bit devices and one for 8-bit devices. It then tells the processor how wide the target is through two active-low size inputs. For narrow targets it produces the low address bits and the active-low high/low byte strobes. It also routes data between processor byte lanes and memory lanes in both directions.

The adapter handles one bus cycle at a time. A cycle begins in the clock in which the address strobe is sampled low. It ends after the clock in which ready is sampled low. Splitting a wide access into several narrow ones is left to the processor. The processor drives valid write data only on enabled lanes and never copies it into lower lanes. The adapter therefore moves upper-lane write data down to the narrow port itself.

Top module: `bus_width_adapter`

## Requirements
- R1: While no cycle is in progress, every output is inactive: `bs16_n`, `bs8_n`, `mem_bhe_n` and `mem_ble_n` are 1; the three chip selects are 0; `mem_addr_lo`, `mem_wdata` and `cpu_rdata` are all zero.
- R2: The target width comes from the byte address `{cpu_word_addr, 2'b00}`. A match in the 8-bit region (`(addr ^ BASE8) & MASK8 == 0`) selects 8-bit, and this match wins over the 16-bit region. Otherwise a match in the 16-bit region selects 16-bit. Any other address selects 32-bit. Exactly one of `mem_cs32/mem_cs16/mem_cs8` is 1 during a cycle.
- R3: Both `bs16_n` and `bs8_n` are 1 for a 32-bit target. `bs16_n` alone is 0 for a 16-bit target, and `bs8_n` alone is 0 for an 8-bit target. They are valid in the same cycle in which the address strobe is low.
- R4: For a 16-bit target, `mem_addr_lo[1]` is 0 when byte enable 0 or 1 is asserted and 1 otherwise, and `mem_addr_lo[0]` is 0. With bit 1 at 0, `mem_ble_n`/`mem_bhe_n` copy `cpu_be_n[0]`/`cpu_be_n[1]`. With bit 1 at 1, they copy `cpu_be_n[2]`/`cpu_be_n[3]`.
- R5: For a 16-bit target, `mem_wdata` carries processor bits 15..0 when address bit 1 is 0 and bits 31..16 when it is 1.
- R6: For an 8-bit target, `mem_addr_lo` is the number of the lowest asserted byte enable (0 if none is asserted). `mem_ble_n` is 0 exactly when some enable is asserted, and `mem_bhe_n` is 1.
- R7: For an 8-bit target, `mem_wdata[7:0]` carries the processor lane named by `mem_addr_lo`, and `mem_wdata[15:8]` is 0.
- R8: For a 32-bit target, `cpu_rdata` equals `mem_rdata32`, `mem_addr_lo` and `mem_wdata` are 0, and both byte strobes are 1. For a 16-bit target, `cpu_rdata` is `mem_rdata16` zero-extended. For an 8-bit target, it is `mem_rdata16[7:0]` zero-extended.
- R9: Once started, a cycle keeps all outputs valid through the clock in which `rdy_n` is sampled low. From the next clock the outputs are inactive, unless a new address strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_n | input | 1 | Active-low address strobe, starts a cycle |
| rdy_n | input | 1 | Active-low ready, ends a cycle |
| cpu_word_addr | input | ADDR_W-2 | Processor word address (byte address bits ADDR_W-1..2) |
| cpu_be_n | input | 4 | Active-low byte enables, bit i for lane i |
| cpu_wdata | input | 32 | Processor write data |
| mem_rdata32 | input | 32 | Read data from 32-bit memory |
| mem_rdata16 | input | 16 | Read data from the narrow memory port |
| cpu_rdata | output | 32 | Read data returned to the processor |
| bs16_n | output | 1 | Active-low 16-bit size indication |
| bs8_n | output | 1 | Active-low 8-bit size indication |
| mem_cs32 | output | 1 | 32-bit region selected |
| mem_cs16 | output | 1 | 16-bit region selected |
| mem_cs8 | output | 1 | 8-bit region selected |
| mem_addr_lo | output | 2 | Generated address bits 1..0 for narrow memory |
| mem_bhe_n | output | 1 | Active-low high-byte strobe |
| mem_ble_n | output | 1 | Active-low low-byte strobe |
| mem_wdata | output | 16 | Write data to the narrow memory port |

## Verification
The bench builds the adapter with an 8-bit address (`ADDR_W=8`). The 16-bit region is set to byte addresses 0x40–0x7F, and the 8-bit region to 0x60–0x7F, which lies inside it. With these values all 64 word addresses and all 16 byte-enable patterns can be swept in full, 1024 cycles in all. The sweep covers plain 32-bit space, the 16-bit-only region and the overlap where the 8-bit priority must win. Every cycle is checked in its address phase, in its ready phase and in the idle clock after it, so the hold and release behaviour is exercised at each address.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    TGT_W32 = 2'd0,
    TGT_W16 = 2'd1,
    TGT_W8  = 2'd2
  } tgt_width_e;

  // 1 when neither lane 0 nor lane 1 is enabled: the access sits in the upper half
  function automatic logic upper_half(input logic [3:0] be_n);
    return be_n[0] & be_n[1];
  endfunction

  // Number of the lowest enabled lane, 0 when no lane is enabled
  function automatic logic [1:0] first_lane(input logic [3:0] be_n);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (!be_n[i]) idx = 2'(i);
    end
    return idx;
  endfunction

  function automatic logic any_lane(input logic [3:0] be_n);
    return ~&be_n;
  endfunction

endpackage

// File: rtl/bwa_region_decode.sv
module bwa_region_decode
  import bwa_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE16 = '0,
  parameter logic [ADDR_W-1:0] MASK16 = '0,
  parameter logic [ADDR_W-1:0] BASE8  = '0,
  parameter logic [ADDR_W-1:0] MASK8  = '0
) (
  input  logic [ADDR_W-1:2] word_addr,
  output tgt_width_e        width,
  output logic              hit16,
  output logic              hit8
);
  localparam logic [ADDR_W-1:2] B16 = BASE16[ADDR_W-1:2];
  localparam logic [ADDR_W-1:2] M16 = MASK16[ADDR_W-1:2];
  localparam logic [ADDR_W-1:2] B8  = BASE8[ADDR_W-1:2];
  localparam logic [ADDR_W-1:2] M8  = MASK8[ADDR_W-1:2];

  assign hit16 = ((word_addr ^ B16) & M16) == '0;
  assign hit8  = ((word_addr ^ B8)  & M8)  == '0;

  always_comb begin
    if (hit8)       width = TGT_W8;
    else if (hit16) width = TGT_W16;
    else            width = TGT_W32;
  end
endmodule

// File: rtl/bwa_cycle_track.sv
module bwa_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ads_n,
  input  logic rdy_n,
  output logic active
);
  logic cyc_q;

  assign active = ~ads_n | cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= 1'b0;
    else        cyc_q <= active & rdy_n;
  end
endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer
  import bwa_pkg::*;
(
  input  logic        active,
  input  tgt_width_e  width,
  input  logic [3:0]  be_n,
  input  logic [31:0] wdata,
  input  logic [31:0] rdata32,
  input  logic [15:0] rdata16,
  output logic [31:0] rdata,
  output logic        bs16_n,
  output logic        bs8_n,
  output logic        cs32,
  output logic        cs16,
  output logic        cs8,
  output logic [1:0]  addr_lo,
  output logic        bhe_n,
  output logic        ble_n,
  output logic [15:0] wdata16
);
  logic       a1_16;
  logic [1:0] lane8;
  logic [7:0] byte8;

  assign a1_16 = upper_half(be_n);
  assign lane8 = first_lane(be_n);

  always_comb begin
    case (lane8)
      2'd0:    byte8 = wdata[7:0];
      2'd1:    byte8 = wdata[15:8];
      2'd2:    byte8 = wdata[23:16];
      default: byte8 = wdata[31:24];
    endcase
  end

  always_comb begin
    rdata   = '0;
    bs16_n  = 1'b1;
    bs8_n   = 1'b1;
    cs32    = 1'b0;
    cs16    = 1'b0;
    cs8     = 1'b0;
    addr_lo = 2'b00;
    bhe_n   = 1'b1;
    ble_n   = 1'b1;
    wdata16 = '0;
    if (active) begin
      unique case (width)
        TGT_W16: begin
          cs16    = 1'b1;
          bs16_n  = 1'b0;
          addr_lo = {a1_16, 1'b0};
          ble_n   = a1_16 ? be_n[2] : be_n[0];
          bhe_n   = a1_16 ? be_n[3] : be_n[1];
          wdata16 = a1_16 ? wdata[31:16] : wdata[15:0];
          rdata   = {16'h0000, rdata16};
        end
        TGT_W8: begin
          cs8     = 1'b1;
          bs8_n   = 1'b0;
          addr_lo = lane8;
          ble_n   = ~any_lane(be_n);
          wdata16 = {8'h00, byte8};
          rdata   = {24'h000000, rdata16[7:0]};
        end
        default: begin
          cs32  = 1'b1;
          rdata = rdata32;
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE16 = ADDR_W'(32'h0001_0000),
  parameter logic [ADDR_W-1:0] MASK16 = ADDR_W'(32'hFFFF_0000),
  parameter logic [ADDR_W-1:0] BASE8  = ADDR_W'(32'h0002_0000),
  parameter logic [ADDR_W-1:0] MASK8  = ADDR_W'(32'hFFFF_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              rdy_n,
  input  logic [ADDR_W-1:2] cpu_word_addr,
  input  logic [3:0]        cpu_be_n,
  input  logic [31:0]       cpu_wdata,
  input  logic [31:0]       mem_rdata32,
  input  logic [15:0]       mem_rdata16,
  output logic [31:0]       cpu_rdata,
  output logic              bs16_n,
  output logic              bs8_n,
  output logic              mem_cs32,
  output logic              mem_cs16,
  output logic              mem_cs8,
  output logic [1:0]        mem_addr_lo,
  output logic              mem_bhe_n,
  output logic              mem_ble_n,
  output logic [15:0]       mem_wdata
);
  // Named internal events, visible to the bound checker
  logic       cyc_active;
  tgt_width_e tgt_width;
  logic       hit16;
  logic       hit8;

  bwa_cycle_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .ads_n  (ads_n),
    .rdy_n  (rdy_n),
    .active (cyc_active)
  );

  bwa_region_decode #(
    .ADDR_W (ADDR_W),
    .BASE16 (BASE16),
    .MASK16 (MASK16),
    .BASE8  (BASE8),
    .MASK8  (MASK8)
  ) u_decode (
    .word_addr (cpu_word_addr),
    .width     (tgt_width),
    .hit16     (hit16),
    .hit8      (hit8)
  );

  bwa_lane_steer u_steer (
    .active  (cyc_active),
    .width   (tgt_width),
    .be_n    (cpu_be_n),
    .wdata   (cpu_wdata),
    .rdata32 (mem_rdata32),
    .rdata16 (mem_rdata16),
    .rdata   (cpu_rdata),
    .bs16_n  (bs16_n),
    .bs8_n   (bs8_n),
    .cs32    (mem_cs32),
    .cs16    (mem_cs16),
    .cs8     (mem_cs8),
    .addr_lo (mem_addr_lo),
    .bhe_n   (mem_bhe_n),
    .ble_n   (mem_ble_n),
    .wdata16 (mem_wdata)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_n,
  input logic              rdy_n,
  input logic [ADDR_W-1:2] cpu_word_addr,
  input logic [3:0]        cpu_be_n,
  input logic              cyc_active,
  input logic              hit8,
  input logic              hit16,
  input logic              bs16_n,
  input logic              bs8_n,
  input logic              mem_cs32,
  input logic              mem_cs16,
  input logic              mem_cs8,
  input logic [1:0]        mem_addr_lo,
  input logic              mem_bhe_n,
  input logic              mem_ble_n
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_active |-> (bs16_n && bs8_n && mem_bhe_n && mem_ble_n && !mem_cs32 && !mem_cs16 && !mem_cs8)); // R1

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> ($countones({mem_cs32, mem_cs16, mem_cs8}) == 1)); // R2

  AST_NARROW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && hit8 && hit16) |-> (!bs8_n && bs16_n)); // R2

  AST_SIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bs16_n && !bs8_n)); // R3

  AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs16 |-> (mem_addr_lo[0] == 1'b0)); // R4

  AST_BYTE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs8 |-> mem_bhe_n); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && ads_n && $stable(cpu_word_addr) && $stable(cpu_be_n))
      |-> ($stable(bs16_n) && $stable(bs8_n) && $stable(mem_addr_lo))); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && !rdy_n) |=> (ads_n -> (bs16_n && bs8_n))); // R9
endmodule

bind bus_width_adapter bwa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ads_n         (ads_n),
  .rdy_n         (rdy_n),
  .cpu_word_addr (cpu_word_addr),
  .cpu_be_n      (cpu_be_n),
  .cyc_active    (cyc_active),
  .hit8          (hit8),
  .hit16         (hit16),
  .bs16_n        (bs16_n),
  .bs8_n         (bs8_n),
  .mem_cs32      (mem_cs32),
  .mem_cs16      (mem_cs16),
  .mem_cs8       (mem_cs8),
  .mem_addr_lo   (mem_addr_lo),
  .mem_bhe_n     (mem_bhe_n),
  .mem_ble_n     (mem_ble_n)
);

// File: tb/bus_width_adapter_bench.sv
`timescale 1ns/1ps
module bus_width_adapter_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_n = 1'b1;
  logic          rdy_n = 1'b1;
  logic [AW-1:2] cpu_word_addr = '0;
  logic [3:0]    cpu_be_n = 4'hF;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   mem_rdata32 = '0;
  logic [15:0]   mem_rdata16 = '0;
  logic [31:0]   cpu_rdata;
  logic          bs16_n, bs8_n, mem_cs32, mem_cs16, mem_cs8;
  logic [1:0]    mem_addr_lo;
  logic          mem_bhe_n, mem_ble_n;
  logic [15:0]   mem_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_width_adapter #(
    .ADDR_W (AW),
    .BASE16 (8'h40), .MASK16 (8'hC0),
    .BASE8  (8'h60), .MASK8  (8'hE0)
  ) u_bus_width_adapter (
    .clk (clk), .rst_n (rst_n), .ads_n (ads_n), .rdy_n (rdy_n),
    .cpu_word_addr (cpu_word_addr), .cpu_be_n (cpu_be_n), .cpu_wdata (cpu_wdata),
    .mem_rdata32 (mem_rdata32), .mem_rdata16 (mem_rdata16), .cpu_rdata (cpu_rdata),
    .bs16_n (bs16_n), .bs8_n (bs8_n), .mem_cs32 (mem_cs32), .mem_cs16 (mem_cs16),
    .mem_cs8 (mem_cs8), .mem_addr_lo (mem_addr_lo), .mem_bhe_n (mem_bhe_n),
    .mem_ble_n (mem_ble_n), .mem_wdata (mem_wdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1: everything inactive
  task automatic check_idle(input string tag);
    check("R1", {tag, " bs16_n"}, 32'(bs16_n), 32'd1);
    check("R1", {tag, " bs8_n"}, 32'(bs8_n), 32'd1);
    check("R1", {tag, " cs"}, {29'd0, mem_cs32, mem_cs16, mem_cs8}, 32'd0);
    check("R1", {tag, " strobes"}, {30'd0, mem_bhe_n, mem_ble_n}, 32'd3);
    check("R1", {tag, " addr_lo"}, 32'(mem_addr_lo), 32'd0);
    check("R1", {tag, " wdata"}, 32'(mem_wdata), 32'd0);
    check("R1", {tag, " rdata"}, cpu_rdata, 32'd0);
  endtask

  // Expected behaviour restated from the requirements
  task automatic check_active(input string tag);
    int  byte_addr;
    int  width;       // 32, 16 or 8
    int  low;         // lowest enabled lane, -1 if none
    logic [1:0]  e_lo;
    logic        e_bhe, e_ble;
    logic [15:0] e_wd;
    logic [31:0] e_rd;
    string r;
    byte_addr = int'(cpu_word_addr) * 4;
    if (byte_addr >= 'h60 && byte_addr <= 'h7F)      width = 8;
    else if (byte_addr >= 'h40 && byte_addr <= 'h7F) width = 16;
    else                                             width = 32;
    low = -1;
    for (int k = 3; k >= 0; k--) if (cpu_be_n[k] == 1'b0) low = k;
    r = (width == 8) ? "R2 R3 R6 R7" : (width == 16) ? "R2 R3 R4 R5" : "R2 R3 R8";
    check(r, {tag, " cs"}, {29'd0, mem_cs32, mem_cs16, mem_cs8},
          width == 32 ? 32'd4 : width == 16 ? 32'd2 : 32'd1);
    check(r, {tag, " bs16_n"}, 32'(bs16_n), width == 16 ? 32'd0 : 32'd1);
    check(r, {tag, " bs8_n"}, 32'(bs8_n), width == 8 ? 32'd0 : 32'd1);
    if (width == 32) begin
      e_lo = 2'd0; e_bhe = 1'b1; e_ble = 1'b1; e_wd = 16'h0; e_rd = mem_rdata32;
    end else if (width == 16) begin
      e_lo  = (low == 0 || low == 1) ? 2'd0 : 2'd2;
      e_ble = cpu_be_n[e_lo];
      e_bhe = cpu_be_n[e_lo + 2'd1];
      e_wd  = 16'(cpu_wdata >> (8 * int'(e_lo)));
      e_rd  = 32'(mem_rdata16);
    end else begin
      e_lo  = (low < 0) ? 2'd0 : 2'(low);
      e_ble = (low < 0);
      e_bhe = 1'b1;
      e_wd  = 16'((cpu_wdata >> (8 * int'(e_lo))) & 32'hFF);
      e_rd  = 32'(mem_rdata16 & 16'h00FF);
    end
    check(r, {tag, " addr_lo"}, 32'(mem_addr_lo), 32'(e_lo));
    check(r, {tag, " bhe_n"}, 32'(mem_bhe_n), 32'(e_bhe));
    check(r, {tag, " ble_n"}, 32'(mem_ble_n), 32'(e_ble));
    check(r, {tag, " wdata"}, 32'(mem_wdata), 32'(e_wd));
    check("R8", {tag, " rdata"}, cpu_rdata, e_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check_idle("reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_idle("after reset");
    for (int w = 0; w < 64; w++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        ads_n = 1'b0; rdy_n = 1'b1;
        cpu_word_addr = 6'(w);
        cpu_be_n      = 4'(b);
        cpu_wdata     = 32'h4433_2211 + 32'(w) * 32'h0101_0101 + 32'(b);
        mem_rdata32   = ~cpu_wdata;
        mem_rdata16   = 16'hBE00 ^ 16'(w * 16 + b);
        #1 check_active("address phase");      // R3 same-cycle validity
        @(negedge clk);
        ads_n = 1'b1; rdy_n = 1'b0;
        #1 check_active("ready phase R9");
        @(negedge clk);
        rdy_n = 1'b1;
        #1 check_idle("after ready R9");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule